// File: doc/BRIEF.md
# Fractional-N Feedback Clock Divider

This block divides its input clock by a ratio made of an integer part N and a long binary fraction F. Every output period lasts either N or N+1 input cycles. A phase accumulator of FRAC_W bits adds F once per output period. When that addition overflows, the period is stretched by one input cycle. Over time the average ratio is therefore N + F/2^FRAC_W. The output is a single-cycle pulse that marks the last input cycle of each divided period. The block is meant for the feedback path of a frequency synthesizer, where a fine fractional word sets a frequency offset well below one part per million.

The accumulator value after each pulse is exported as a residue. The one-cycle stretches add a periodic phase step, which shows up as low-frequency jitter. That jitter is deterministic, and its sawtooth shape follows the residue exactly. A loop can use the residue as a predicted phase-error value.

A new ratio is written through a load strobe. The block holds it and applies it only at the next period boundary, so the period in progress always completes at the length it started with.

Top module: `fracn_feedback_div`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tick` is 0 and `residue` is 0. Reset clears the cycle counter and the accumulator, and it takes `ratio_int`/`ratio_frac` as the active ratio.
- R2: A period lasts N+1 input cycles when accumulator + F reaches 2^FRAC_W, and N cycles otherwise. N and F are the active ratio of that period.
- R3: `tick` is high for exactly one input cycle per period, in the last cycle of that period.
- R4: The accumulator changes only at a `tick` edge, where it becomes (accumulator + F) mod 2^FRAC_W. `residue` shows the new value from the next cycle until the next `tick`.
- R5: A value captured with `load` = 1 outside a tick cycle does not change the period in progress. It becomes active for the period that starts after the next `tick`.
- R6: If several loads arrive before a boundary, the last one wins. A load in a tick cycle is applied to the very next period.
- R7: An integer ratio below 2, whether captured at reset or by `load`, is used as 2.
- R8: Starting from reset with a fixed ratio, 2^FRAC_W periods span exactly N·2^FRAC_W + F input cycles, and the residue is 0 again afterwards.
- R9: After reset is released, the first `tick` comes in the N-th input cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset; also captures the ratio inputs |
| ratio_int | input | INT_W | Integer ratio N (values below 2 act as 2) |
| ratio_frac | input | FRAC_W | Fractional ratio word F |
| load | input | 1 | Strobe that captures ratio_int and ratio_frac |
| tick | output | 1 | One-cycle pulse in the last cycle of each divided period |
| residue | output | FRAC_W | Accumulator value, updated at each tick |

## Verification
The bench places loads in the exact cycle of a tick and places several loads inside one period. A divider that applied loads at once would shorten the current period. One that kept the first pending value would run at the wrong ratio. It also loads integer ratios of 0 and 1, which would otherwise make periods of zero or one cycle. One full accumulator cycle is run with a small fraction width. An off-by-one in the carry test, or in the counter, shows up there as a wrong total cycle count or a nonzero final residue. The first period after reset is timed on its own to catch a counter that starts at the wrong value.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

   // Raise a value to a floor; used to keep the integer ratio legal.
   function automatic int unsigned floor_at(input int unsigned v, input int unsigned lo);
      return (v < lo) ? lo : v;
   endfunction

endpackage

// File: rtl/fracn_ratio_hold.sv
module fracn_ratio_hold #(
   parameter int INT_W   = 8,
   parameter int FRAC_W  = 24,
   parameter int MIN_INT = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic              boundary,
   input  logic [INT_W-1:0]  in_int,
   input  logic [FRAC_W-1:0] in_frac,
   output logic [INT_W-1:0]  act_int,
   output logic [FRAC_W-1:0] act_frac
);
   logic [INT_W-1:0]  in_int_c;
   logic [INT_W-1:0]  pend_int;
   logic [FRAC_W-1:0] pend_frac;
   logic              pend_v;

   assign in_int_c = INT_W'(fracn_pkg::floor_at(32'(in_int), MIN_INT));

   always_ff @(posedge clk) begin
      if (rst) begin
         act_int   <= in_int_c;
         act_frac  <= in_frac;
         pend_int  <= '0;
         pend_frac <= '0;
         pend_v    <= 1'b0;
      end else if (boundary) begin
         if (load) begin
            act_int  <= in_int_c;
            act_frac <= in_frac;
         end else if (pend_v) begin
            act_int  <= pend_int;
            act_frac <= pend_frac;
         end
         pend_v <= 1'b0;
      end else if (load) begin
         pend_int  <= in_int_c;
         pend_frac <= in_frac;
         pend_v    <= 1'b1;
      end
   end

   // R5: the active ratio never moves inside a period
   p_ratio_hold_r5: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> ($stable(act_int) && $stable(act_frac)));

   // R7: the active integer ratio is never below the floor
   p_ratio_floor_r7: assert property (@(posedge clk) disable iff (rst)
      32'(act_int) >= MIN_INT);

endmodule

// File: rtl/fracn_phase_acc.sv
module fracn_phase_acc #(
   parameter int FRAC_W = 24
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac,
   output logic [FRAC_W-1:0] acc,
   output logic              carry
);
   logic [FRAC_W:0] sum;

   assign sum   = {1'b0, acc} + {1'b0, frac};
   assign carry = sum[FRAC_W];

   always_ff @(posedge clk) begin
      if (rst)       acc <= '0;
      else if (step) acc <= sum[FRAC_W-1:0];
   end

   // R4: accumulator only moves at a period boundary
   p_acc_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !step |=> $stable(acc));

   // R2: a wrap leaves a remainder smaller than the word that caused it
   p_wrap_rem_r2: assert property (@(posedge clk) disable iff (rst)
      (step && carry) |=> (acc < $past(frac)));

endmodule

// File: rtl/fracn_period_cnt.sv
module fracn_period_cnt #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [CW-1:0] len,
   output logic          tick
);
   logic [CW-1:0] cnt;

   assign tick = (cnt == (len - CW'(1)));

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

   // R3: the count never runs past the period length
   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
      cnt < len);

endmodule

// File: rtl/fracn_feedback_div.sv
module fracn_feedback_div #(
   parameter int INT_W   = 8,
   parameter int FRAC_W  = 24,
   parameter int MIN_INT = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [INT_W-1:0]  ratio_int,
   input  logic [FRAC_W-1:0] ratio_frac,
   input  logic              load,
   output logic              tick,
   output logic [FRAC_W-1:0] residue
);
   localparam int CW = INT_W + 1;

   generate
      if (INT_W < 2) begin : g_bad_int
         $error("INT_W must be at least 2");
      end
      if (FRAC_W < 1) begin : g_bad_frac
         $error("FRAC_W must be at least 1");
      end
      if (MIN_INT < 2 || MIN_INT >= (1 << INT_W)) begin : g_bad_min
         $error("MIN_INT must lie in [2, 2**INT_W)");
      end
   endgenerate

   logic [INT_W-1:0]  act_int;
   logic [FRAC_W-1:0] act_frac;
   logic [FRAC_W-1:0] acc;
   logic              carry;
   logic [CW-1:0]     len;

   fracn_ratio_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W), .MIN_INT(MIN_INT)) u_hold (
      .clk(clk), .rst(rst), .load(load), .boundary(tick),
      .in_int(ratio_int), .in_frac(ratio_frac),
      .act_int(act_int), .act_frac(act_frac));

   fracn_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst(rst), .step(tick), .frac(act_frac),
      .acc(acc), .carry(carry));

   assign len = {1'b0, act_int} + CW'(carry);

   fracn_period_cnt #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .len(len), .tick(tick));

   assign residue = acc;

   // Cycles since the previous tick, kept only for the checks below
   logic [CW-1:0] gap;
   always_ff @(posedge clk) begin
      if (rst || tick) gap <= '0;
      else             gap <= gap + CW'(1);
   end

   // R2: every finished period lasts N or N+1 cycles
   p_len_r2: assert property (@(posedge clk) disable iff (rst)
      tick |-> (((gap + CW'(1)) == {1'b0, act_int}) ||
                ((gap + CW'(1)) == ({1'b0, act_int} + CW'(1)))));

   // R3: the pulse is one cycle wide
   p_tick_pulse_r3: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   // R1: reset leaves a cleared residue and no pulse
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (residue == '0 && !tick));

endmodule

// File: tb/fracn_feedback_div_test.sv
module fracn_feedback_div_test;
   localparam int IW = 8;
   localparam int FW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [IW-1:0] ratio_int = 8'd5;
   logic [FW-1:0] ratio_frac = '0;
   logic          load = 1'b0;
   logic          tick;
   logic [FW-1:0] residue;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   // reference model state
   int unsigned m_n, m_f, m_acc, m_cnt, p_n, p_f;
   bit          p_v;
   bit          seen_tick;
   string       ctx = "R2";

   always #4 clk = ~clk;

   fracn_feedback_div #(.INT_W(IW), .FRAC_W(FW), .MIN_INT(2)) uut (
      .clk(clk), .rst(rst), .ratio_int(ratio_int), .ratio_frac(ratio_frac),
      .load(load), .tick(tick), .residue(residue));

   function automatic int unsigned clampn(input int unsigned n);
      return (n < 2) ? 2 : n;
   endfunction

   function automatic bit model_tick();
      int unsigned s, l;
      s = m_acc + m_f;
      l = m_n + (s >> FW);
      return (m_cnt == l - 1);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Check the present state, drive this cycle's inputs, advance the model.
   task automatic cyc(input bit ld, input int unsigned n, input int unsigned f);
      bit et;
      et = model_tick();
      seen_tick = tick;
      check(tick === et, {ctx, "/R3 tick"}, int'(tick), int'(et));
      check(residue === m_acc[FW-1:0], "R4 residue", int'(residue), int'(m_acc));
      load = ld; ratio_int = n[IW-1:0]; ratio_frac = f[FW-1:0];
      if (et) begin
         m_acc = (m_acc + m_f) % (1 << FW);
         m_cnt = 0;
         if (ld) begin m_n = clampn(n); m_f = f; end
         else if (p_v) begin m_n = p_n; m_f = p_f; end
         p_v = 0;
      end else begin
         m_cnt++;
         if (ld) begin p_n = clampn(n); p_f = f; p_v = 1; end
      end
      @(negedge clk);
   endtask

   task automatic do_reset(input int unsigned n, input int unsigned f);
      @(negedge clk);
      rst = 1'b1; load = 1'b0; ratio_int = n[IW-1:0]; ratio_frac = f[FW-1:0];
      repeat (2) @(negedge clk);
      check(tick === 1'b0, "R1 tick in reset", int'(tick), 0);
      check(residue === '0, "R1 residue in reset", int'(residue), 0);
      rst = 1'b0;
      m_n = clampn(n); m_f = f; m_acc = 0; m_cnt = 0; p_v = 0;
   endtask

   initial begin
      int unsigned total, periods, first;
      void'($urandom(32'd1234));

      // R9 / R1: first period after reset
      ctx = "R9";
      do_reset(5, 700);
      check(tick === 1'b0, "R1 tick after release", int'(tick), 0);
      check(residue === '0, "R1 residue after release", int'(residue), 0);
      first = 0;
      for (int i = 1; i <= 12; i++) begin
         cyc(0, 5, 700);
         if (seen_tick && first == 0) first = i;
      end
      check(first == 5, "R9 first tick cycle", first, 5);

      // R8: one full accumulator cycle
      ctx = "R8";
      do_reset(3, 357);
      total = 0; periods = 0;
      while (periods < (1 << FW)) begin
         cyc(0, 3, 357);
         total++;
         if (seen_tick) periods++;
      end
      check(total == 3 * (1 << FW) + 357, "R8 total cycles", total, 3 * (1 << FW) + 357);
      check(residue === '0, "R8 residue after full cycle", int'(residue), 0);

      // R6: load in the tick cycle
      ctx = "R6";
      do_reset(4, 0);
      while (!model_tick()) cyc(0, 0, 0);
      cyc(1, 7, 100);
      for (int i = 0; i < 20; i++) cyc(0, 0, 0);
      // R6: several loads inside one period, last wins
      cyc(1, 9, 5);
      cyc(1, 6, 900);
      for (int i = 0; i < 30; i++) cyc(0, 0, 0);

      // R5: load mid-period leaves the current period alone
      ctx = "R5";
      while (!model_tick()) cyc(0, 0, 0);
      cyc(0, 0, 0);
      cyc(1, 11, 512);
      for (int i = 0; i < 40; i++) cyc(0, 0, 0);

      // R7: integer ratios 0 and 1
      ctx = "R7";
      do_reset(1, 300);
      for (int i = 0; i < 12; i++) cyc(0, 1, 300);
      cyc(1, 0, 1000);
      for (int i = 0; i < 20; i++) cyc(0, 0, 0);

      // R2: random ratios and load timing
      ctx = "R2";
      do_reset(6, 123);
      for (int i = 0; i < 4000; i++) begin
         int unsigned n, f;
         bit ld;
         n  = ($urandom % 50 == 0) ? 255 : ($urandom % 20);
         f  = $urandom % (1 << FW);
         ld = ($urandom % 25 == 0);
         cyc(ld, n, f);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule